// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Slave

This block is a two-wire serial bus slave that fronts a 128-byte internal memory. Its main job is to serve reads. The master's SCL and SDA lines are sampled on a faster system clock. From those samples the block picks out start, repeated-start and stop conditions. It then decodes a 7-bit device address plus a direction bit, and acknowledges only its own address.

A persistent word-address counter decides which byte a read returns. A bare read returns the byte after the last one accessed. To read from any location, the master first does a dummy write of a word address, then a repeated start and a read. The block also accepts plain byte writes, so the effect of writes on the counter can be observed. SDA is open-drain: the block only ever pulls the line low through an output enable.

Top module: `eeprom_rd_slave`

## Requirements
- R1: A start (SDA falls while SCL is high) begins device-address reception from any state, including in the middle of a byte. A stop (SDA rises while SCL is high) returns the block to idle with SDA released.
- R2: A device-address byte whose upper seven bits equal binary 1010 followed by `dev_sel_i` is acknowledged by pulling SDA low on the ninth clock. Bit 0 selects direction: 1 is read, 0 is write. A mismatching byte gets no acknowledge, and the block leaves SDA released until the next start.
- R3: In a write transfer, the first byte after the device address is a word address. It is acknowledged, and its low seven bits load the counter. Bit 7 is ignored.
- R4: After a word address, a repeated start followed by a read address returns the byte at that word address.
- R5: A read with no preceding word address returns the byte at one past the last location accessed. This holds whether that access was a read or a write.
- R6: Data bytes are driven MSB first. The block changes its SDA drive only after an SCL falling edge, so the line is stable while SCL is high.
- R7: If the master acknowledges a data byte (SDA low on the ninth clock), the next sequential byte follows. If the master does not acknowledge, the block releases SDA and ignores the bus until a new start.
- R8: The counter advances after every byte read or written and wraps from 127 to 0.
- R9: In a write transfer, each byte after the word address is acknowledged and stored at the counter address, and the counter then advances.
- R10: After reset, SDA is released, the counter is 0, and memory location a holds (2·a mod 256) XOR 0xA5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock from the master |
| sda_i | input | 1 | Sampled level of the SDA line |
| dev_sel_i | input | 3 | Low three bits of the device address |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except when it forms a start or stop. They also assume that each SCL phase lasts longer than the input synchroniser delay, so every edge is seen after the slave has settled. The bench's master tasks hold every SCL phase for several system clocks. They move SDA only in the middle of the low phase, and form starts and stops only with SCL held high. The resolved line seen by the block is the wired-AND of the master's drive and the slave's pull-down.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DEV_ACK, S_WADDR, S_WADDR_ACK,
    S_WDATA, S_WDATA_ACK, S_RDATA, S_RD_ACK
  } bus_state_e;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_o      = scl_q[STAGES-1];
  assign sda_o      = sda_q[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_p;
  assign scl_fall_o = ~scl_o & scl_p;
  // conditions: SDA edge while SCL held high
  assign start_o    = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/addr_ctr.sv
module addr_ctr #(
  parameter int AW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_i,
  output logic [AW-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (load_i) addr_o <= load_val_i;
    else if (inc_i)  addr_o <= addr_o + AW'(1);  // natural wrap
  end
endmodule

// File: rtl/byte_mem.sv
module byte_mem #(
  parameter int          AW       = 7,
  parameter int          DW       = 8,
  parameter logic [7:0]  INIT_XOR = 8'hA5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= DW'(i * 2) ^ DW'(INIT_XOR);
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/eeprom_rd_slave.sv
module eeprom_rd_slave
  import eeprom_rd_pkg::*;
#(
  parameter int         AW       = 7,
  parameter logic [3:0] DEV_TYPE = 4'b1010,
  parameter int         SYNC_N   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] dev_sel_i,
  output logic       sda_oe_o
);
  localparam int DW = 8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  bus_state_e    state;
  logic [2:0]    cnt;
  logic [DW-1:0] sh, tx, mem_rdata;
  logic          rw, got, acked, oe;
  logic [AW-1:0] ctr;
  logic          ctr_load, ctr_inc, mem_we, rx_state;

  twi_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  always_comb begin
    rx_state = (state == S_DEV) || (state == S_WADDR) || (state == S_WDATA);
    ctr_load = !start_det && !stop_det && state == S_WADDR && scl_fall && got;
    mem_we   = !start_det && !stop_det && state == S_WDATA && scl_fall && got;
    ctr_inc  = mem_we ||
               (!start_det && !stop_det && state == S_RDATA && scl_fall && cnt == 3'd7);
  end

  addr_ctr #(.AW(AW)) u_ctr (
    .clk_i, .rst_ni, .load_i(ctr_load), .load_val_i(sh[AW-1:0]),
    .inc_i(ctr_inc), .addr_o(ctr)
  );

  byte_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk_i, .rst_ni, .we_i(mem_we), .addr_i(ctr), .wdata_i(sh), .rdata_o(mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= S_IDLE;
      cnt   <= '0;
      sh    <= '0;
      tx    <= '0;
      rw    <= 1'b0;
      got   <= 1'b0;
      acked <= 1'b0;
      oe    <= 1'b0;
    end else if (start_det) begin
      state <= S_DEV;
      cnt   <= '0;
      got   <= 1'b0;
      oe    <= 1'b0;
    end else if (stop_det) begin
      state <= S_IDLE;
      got   <= 1'b0;
      oe    <= 1'b0;
    end else begin
      if (scl_rise && rx_state) begin
        sh  <= {sh[DW-2:0], sda_s};
        cnt <= cnt + 3'd1;
        if (cnt == 3'd7) got <= 1'b1;
      end
      unique case (state)
        S_DEV: if (scl_fall && got) begin
          got <= 1'b0;
          if (sh[7:1] == {DEV_TYPE, dev_sel_i}) begin
            state <= S_DEV_ACK;
            oe    <= 1'b1;
            rw    <= sh[0];
          end else begin
            state <= S_IDLE;
          end
        end
        S_DEV_ACK: if (scl_fall) begin
          if (rw) begin
            state <= S_RDATA;
            tx    <= mem_rdata;
            oe    <= ~mem_rdata[7];
            cnt   <= '0;
          end else begin
            state <= S_WADDR;
            oe    <= 1'b0;
          end
        end
        S_WADDR: if (scl_fall && got) begin
          got   <= 1'b0;
          state <= S_WADDR_ACK;
          oe    <= 1'b1;
        end
        S_WADDR_ACK: if (scl_fall) begin
          state <= S_WDATA;
          oe    <= 1'b0;
        end
        S_WDATA: if (scl_fall && got) begin
          got   <= 1'b0;
          state <= S_WDATA_ACK;
          oe    <= 1'b1;
        end
        S_WDATA_ACK: if (scl_fall) begin
          state <= S_WDATA;
          oe    <= 1'b0;
        end
        S_RDATA: if (scl_fall) begin
          if (cnt == 3'd7) begin
            state <= S_RD_ACK;
            oe    <= 1'b0;
          end else begin
            tx  <= {tx[DW-2:0], 1'b0};
            oe  <= ~tx[DW-2];
            cnt <= cnt + 3'd1;
          end
        end
        S_RD_ACK: begin
          if (scl_rise) acked <= ~sda_s;
          if (scl_fall) begin
            if (acked) begin
              state <= S_RDATA;
              tx    <= mem_rdata;
              oe    <= ~mem_rdata[7];
              cnt   <= '0;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: oe <= 1'b0;
      endcase
    end
  end

  assign sda_oe_o = oe;
endmodule

// File: rtl/eeprom_rd_slave_chk.sv
module eeprom_rd_slave_chk
  import eeprom_rd_pkg::*;
#(
  parameter int AW = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_s,
  input logic          scl_fall,
  input logic          start_det,
  input logic          stop_det,
  input bus_state_e    state,
  input logic [AW-1:0] ctr,
  input logic          sda_oe_o
);
  // R6
  oe_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> $past(scl_fall || start_det || stop_det));

  // R6
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s);

  // R1
  start_dev_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> (state == S_DEV && !sda_oe_o));

  // R1
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_det && !start_det) |=> (state == S_IDLE && !sda_oe_o));

  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_IDLE) |-> !sda_oe_o);

  // R8
  ctr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ctr != $past(ctr)) && $past(state) != S_WADDR) |-> (ctr == $past(ctr) + AW'(1)));
endmodule

bind eeprom_rd_slave eeprom_rd_slave_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .scl_fall(scl_fall),
  .start_det(start_det), .stop_det(stop_det), .state(state), .ctr(ctr),
  .sda_oe_o(sda_oe_o)
);

// File: tb/eeprom_rd_slave_test.sv
module eeprom_rd_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam logic [2:0] SEL = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, SEL, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, SEL, 1'b1};
  // {word address byte, expected data}
  localparam logic [15:0] VEC [6] = '{
    {8'h00, 8'hA5}, {8'h10, 8'h85}, {8'h40, 8'h25},
    {8'h2A, 8'hF1}, {8'h81, 8'hA7}, {8'h7F, 8'h5B}
  };

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_oe ? 1'b0 : sda_m;

  eeprom_rd_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .dev_sel_i(SEL), .sda_oe_o(sda_oe)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bit(logic b);
    sda_m = b;    tick(Q);
    scl_m = 1'b1; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic wr_byte(logic [7:0] b, output logic ack_n);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack_n = sda_line;
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic rd_byte(bit mack, output logic [7:0] b);
    logic first, moved;
    moved = 1'b0;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(Q);
      scl_m = 1'b1; tick(1);
      first = sda_line; tick(Q - 1);
      if (sda_line != first) moved = 1'b1;
      b = {b[6:0], sda_line};
      scl_m = 1'b0;
    end
    chk(!moved, "R6 sda stable while scl high", 32'(moved), 32'd0);
    tick(Q);
    send_bit(mack ? 1'b0 : 1'b1);
    sda_m = 1'b1;
  endtask

  task automatic rand_read(logic [7:0] wa, output logic [7:0] d, output logic [2:0] acks);
    logic a0, a1, a2;
    bus_start(); wr_byte(DEV_W, a0); wr_byte(wa, a1);
    bus_start(); wr_byte(DEV_R, a2);
    rd_byte(1'b0, d); bus_stop();
    acks = {a0, a1, a2};
  endtask

  task automatic cur_read(output logic [7:0] d, output logic ack_n);
    bus_start(); wr_byte(DEV_R, ack_n);
    rd_byte(1'b0, d); bus_stop();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d, d1, d2;
    logic [2:0] acks;
    logic an, a0, a1, a2;
    tick(3); rst_n = 1'b1; tick(3);
    chk(sda_oe == 1'b0, "R10 reset releases sda", 32'(sda_oe), 32'd0);

    // R4 R3 R2 table of random reads; last one leaves counter at 127+1
    for (int v = 0; v < 6; v++) begin
      rand_read(VEC[v][15:8], d, acks);
      chk(acks == 3'b000, "R2/R3 acknowledges", 32'(acks), 32'd0);
      chk(d == VEC[v][7:0], "R4 random read data", 32'(d), 32'(VEC[v][7:0]));
    end

    // R8 R5 wrap after reading 0x7F
    cur_read(d, an);
    chk(an == 1'b0, "R5 current read ack", 32'(an), 32'd0);
    chk(d == 8'hA5, "R8 wrap to 0", 32'(d), 32'hA5);

    // R5 after a read
    rand_read(8'h2A, d, acks);
    cur_read(d, an);
    chk(d == 8'hF3, "R5 next after read", 32'(d), 32'hF3);

    // R7 sequential read across wrap
    bus_start(); wr_byte(DEV_W, a0); wr_byte(8'h7E, a1);
    bus_start(); wr_byte(DEV_R, a2);
    rd_byte(1'b1, d); rd_byte(1'b1, d1); rd_byte(1'b0, d2);
    tick(4 * Q);
    chk(sda_oe == 1'b0, "R7 released after nack", 32'(sda_oe), 32'd0);
    bus_stop();
    chk({d, d1, d2} == 24'h595BA5, "R7/R8 sequential bytes", 32'({d, d1, d2}), 32'h595BA5);

    // R9 byte write then counter
    bus_start(); wr_byte(DEV_W, a0); wr_byte(8'h05, a1); wr_byte(8'h3C, a2); bus_stop();
    chk({a0, a1, a2} == 3'b000, "R9 write acks", 32'({a0, a1, a2}), 32'd0);
    cur_read(d, an);
    chk(d == 8'hA9, "R5 next after write", 32'(d), 32'hA9);
    rand_read(8'h05, d, acks);
    chk(d == 8'h3C, "R9 stored byte", 32'(d), 32'h3C);

    // R2 mismatching device address
    bus_start(); wr_byte({4'b1010, 3'b001, 1'b1}, an);
    chk(an == 1'b1, "R2 no ack on mismatch", 32'(an), 32'd1);
    wr_byte(8'h00, a0);
    chk(a0 == 1'b1 && sda_oe == 1'b0, "R2 stays off bus", 32'({a0, sda_oe}), 32'h2);
    bus_stop();

    // R1 start recovers; counter at 6
    cur_read(d, an);
    chk(an == 1'b0 && d == 8'hA9, "R1 read after mismatch", 32'({an, d}), 32'hA9);

    // R1 start in the middle of a byte
    bus_start(); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_start(); wr_byte(DEV_R, an);
    rd_byte(1'b0, d); bus_stop();
    chk(an == 1'b0 && d == 8'hAB, "R1 restart mid-byte", 32'({an, d}), 32'hAB);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule